// File: doc/BRIEF.md
# Row-Hit-First Memory Request Scheduler

This block sits in front of a multi-bank DRAM and holds a small pool of pending read and write requests. Each request names a bank, a row, a column and the thread that issued it, and the pool remembers the order in which requests arrived. In every cycle the scheduler issues at most one request. It prefers a request that targets the row already open in its bank. When no such request is ready, it issues the oldest request that is ready.

For each bank the scheduler keeps the open row and a busy timer. An access that hits the open row keeps its bank busy for a short time. An access that misses closes the old row and opens the new one, and this keeps the bank busy for longer. A bank that is still busy cannot take a new request.

Every issued access leaves the block marked as a hit or a conflict. Per-thread issue counters are exported, so that a test environment can measure how unevenly the threads are served. Because a stream of hits can keep overtaking older requests without limit, a sequential stream can starve a random-access one.

Top module: `rowhit_sched`

## Requirements
- R1: A ready request whose row equals the open row of its bank is issued before any ready request that does not hit.
- R2: Among ready requests of the same class (all hits, or all non-hits), the one accepted earliest is issued first.
- R3: A hit keeps its bank busy for `HIT_CYC` cycles (default 1) and a conflict for `MISS_CYC` cycles (default 4), counting the issue cycle. A request to a busy bank is not issued, but requests to other banks still are.
- R4: Each bank has one open row, and every issue to a bank replaces that row with the issued row. After reset no bank has an open row, so the first access to each bank is reported with `iss_hit`=0. A later access to a row other than the open one also reports 0.
- R5: The pool holds `DEPTH` requests (default 16). `in_ready` is low exactly when the pool is full, and while it is low `in_valid` is ignored, so no request is lost or duplicated.
- R6: At most one request is issued per cycle. The issue port (`iss_valid` and its fields) is valid in the same cycle the scheduler picks a request. A request accepted at a clock edge can be issued in the cycle that follows that edge.
- R7: Nothing limits a run of hits. A hit stream that keeps arriving to one open row is served completely before an older conflicting request to the same bank.
- R8: `thr_count` holds one `CNT_W`-bit counter per thread. Thread t occupies bits [t*CNT_W +: CNT_W]. Each counter increments once for every issued request from its thread and saturates at its maximum value.
- R9: After reset the pool is empty. In that state `in_ready`=1, `iss_valid`=0 and every counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Enqueue request valid |
| in_ready | output | 1 | Pool has a free entry |
| in_bank | input | BANK_W | Target bank |
| in_row | input | ROW_W | Target row |
| in_col | input | COL_W | Target column |
| in_thr | input | THR_W | Issuing thread |
| in_write | input | 1 | 1 = write, 0 = read |
| iss_valid | output | 1 | A request is issued this cycle |
| iss_bank | output | BANK_W | Bank of issued request |
| iss_row | output | ROW_W | Row of issued request |
| iss_col | output | COL_W | Column of issued request |
| iss_thr | output | THR_W | Thread of issued request |
| iss_write | output | 1 | Write flag of issued request |
| iss_hit | output | 1 | 1 = open-row hit, 0 = conflict |
| thr_count | output | NTHR*CNT_W | Per-thread issue counters |

## Verification
Most arrivals are issued the cycle after they are accepted, so the hard part is getting several requests to compete for one bank at the same time. The stimulus first sends a cold conflict to a bank, which keeps that bank busy for four cycles. While it is busy, the next requests arrive one per cycle and pile up in the pool. When the bank frees, the hit-before-age rule and the age rule within each class can both be seen in the issue order and its cycle spacing.

Filling the pool works the same way. A long run of requests, each to a different row of one bank, drains at only one per four cycles, so the pool fills and `in_ready` drops while attempts keep arriving.

// File: rtl/rowhit_sched.sv
module rowhit_sched #(
  parameter int DEPTH    = 16,
  parameter int NBANK    = 4,
  parameter int ROW_W    = 8,
  parameter int COL_W    = 6,
  parameter int NTHR     = 4,
  parameter int CNT_W    = 16,
  parameter int HIT_CYC  = 1,
  parameter int MISS_CYC = 4,
  localparam int BANK_W  = $clog2(NBANK),
  localparam int THR_W   = $clog2(NTHR)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BANK_W-1:0]       in_bank,
  input  logic [ROW_W-1:0]        in_row,
  input  logic [COL_W-1:0]        in_col,
  input  logic [THR_W-1:0]        in_thr,
  input  logic                    in_write,
  output logic                    iss_valid,
  output logic [BANK_W-1:0]       iss_bank,
  output logic [ROW_W-1:0]        iss_row,
  output logic [COL_W-1:0]        iss_col,
  output logic [THR_W-1:0]        iss_thr,
  output logic                    iss_write,
  output logic                    iss_hit,
  output logic [NTHR*CNT_W-1:0]   thr_count
);

  localparam int IDX_W  = $clog2(DEPTH);
  localparam int BUSY_W = $clog2(MISS_CYC + 1);
  localparam logic [BUSY_W-1:0] HIT_HOLD  = BUSY_W'(HIT_CYC - 1);
  localparam logic [BUSY_W-1:0] MISS_HOLD = BUSY_W'(MISS_CYC - 1);

  // request pool
  logic [DEPTH-1:0]  q_vld;
  logic [BANK_W-1:0] q_bank [DEPTH];
  logic [ROW_W-1:0]  q_row  [DEPTH];
  logic [COL_W-1:0]  q_col  [DEPTH];
  logic [THR_W-1:0]  q_thr  [DEPTH];
  logic [DEPTH-1:0]  q_wr;
  // ahead[i][j] = 1 : entry j arrived before entry i
  logic [DEPTH-1:0]  ahead  [DEPTH];

  // per-bank state
  logic [NBANK-1:0]  open_vld;
  logic [ROW_W-1:0]  open_row [NBANK];
  logic [BUSY_W-1:0] busy     [NBANK];

  logic [CNT_W-1:0]  cnt [NTHR];

  logic [DEPTH-1:0]  ready_v, hit_v, cand, grant;
  logic [IDX_W-1:0]  gidx, fidx;
  logic              enq;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ready_v[i] = q_vld[i] && (busy[q_bank[i]] == '0);
      hit_v[i]   = ready_v[i] && open_vld[q_bank[i]] && (open_row[q_bank[i]] == q_row[i]);
    end
  end

  assign cand = (|hit_v) ? hit_v : ready_v;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      grant[i] = cand[i] && !(|(cand & ahead[i]));
  end

  always_comb begin
    gidx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (grant[i]) gidx = IDX_W'(i);
  end

  always_comb begin
    fidx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!q_vld[i]) fidx = IDX_W'(i);
  end

  assign in_ready  = ~&q_vld;
  assign enq       = in_valid && in_ready;

  assign iss_valid = |grant;
  assign iss_bank  = q_bank[gidx];
  assign iss_row   = q_row[gidx];
  assign iss_col   = q_col[gidx];
  assign iss_thr   = q_thr[gidx];
  assign iss_write = q_wr[gidx];
  assign iss_hit   = iss_valid && open_vld[iss_bank] && (open_row[iss_bank] == iss_row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_vld <= '0;
      q_wr  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_bank[i] <= '0;
        q_row[i]  <= '0;
        q_col[i]  <= '0;
        q_thr[i]  <= '0;
        ahead[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (iss_valid && gidx == IDX_W'(i)) q_vld[i] <= 1'b0;
        if (enq && fidx == IDX_W'(i)) begin
          q_vld[i]  <= 1'b1;
          q_bank[i] <= in_bank;
          q_row[i]  <= in_row;
          q_col[i]  <= in_col;
          q_thr[i]  <= in_thr;
          q_wr[i]   <= in_write;
        end
        for (int j = 0; j < DEPTH; j++) begin
          if (enq && fidx == IDX_W'(i))
            ahead[i][j] <= q_vld[j] && !grant[j];
          else if (enq && fidx == IDX_W'(j))
            ahead[i][j] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_vld <= '0;
      for (int b = 0; b < NBANK; b++) begin
        open_row[b] <= '0;
        busy[b]     <= '0;
      end
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (iss_valid && iss_bank == BANK_W'(b)) begin
          busy[b]     <= iss_hit ? HIT_HOLD : MISS_HOLD;
          open_row[b] <= iss_row;
          open_vld[b] <= 1'b1;
        end else if (busy[b] != '0) begin
          busy[b] <= busy[b] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) cnt[t] <= '0;
    end else if (iss_valid && !(&cnt[iss_thr])) begin
      cnt[iss_thr] <= cnt[iss_thr] + 1'b1;
    end
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_cnt
    assign thr_count[t*CNT_W +: CNT_W] = cnt[t];
  end

  a_r3_miss_gap1: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && $past(iss_valid && !iss_hit) && MISS_CYC > 1) |-> iss_bank != $past(iss_bank))
    else $error("conflict bank reissued after one cycle");

  a_r3_miss_gap2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && $past(iss_valid && !iss_hit, 2) && MISS_CYC > 2) |-> iss_bank != $past(iss_bank, 2))
    else $error("conflict bank reissued after two cycles");

  a_r4_hit_same_row: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_hit && $past(iss_valid) && $past(iss_bank) == iss_bank) |-> iss_row == $past(iss_row))
    else $error("hit on a row other than the one just opened");

  a_r5_full_after_enq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid))
    else $error("pool filled without an enqueue");

  a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant))
    else $error("more than one request granted");

endmodule

// File: tb/test_rowhit_sched.sv
module test_rowhit_sched;
  localparam int DEPTH = 16, NBANK = 4, ROW_W = 8, COL_W = 6, NTHR = 4, CNT_W = 16;
  localparam int BANK_W = 2, THR_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_write = 1'b0;
  logic in_ready;
  logic [BANK_W-1:0] in_bank = '0;
  logic [ROW_W-1:0]  in_row = '0;
  logic [COL_W-1:0]  in_col = '0;
  logic [THR_W-1:0]  in_thr = '0;
  logic iss_valid, iss_write, iss_hit;
  logic [BANK_W-1:0] iss_bank;
  logic [ROW_W-1:0]  iss_row;
  logic [COL_W-1:0]  iss_col;
  logic [THR_W-1:0]  iss_thr;
  logic [NTHR*CNT_W-1:0] thr_count;

  always #2.5 clk = ~clk;

  rowhit_sched #(.DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .COL_W(COL_W),
                 .NTHR(NTHR), .CNT_W(CNT_W)) i_rowhit_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bank(in_bank), .in_row(in_row), .in_col(in_col), .in_thr(in_thr),
    .in_write(in_write), .iss_valid(iss_valid), .iss_bank(iss_bank),
    .iss_row(iss_row), .iss_col(iss_col), .iss_thr(iss_thr),
    .iss_write(iss_write), .iss_hit(iss_hit), .thr_count(thr_count));

  int n_chk = 0, n_fail = 0;
  int cyc = 0, n_log = 0;
  int lb[256], lr[256], lc[256], lt[256], lh[256], lk[256];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && iss_valid && n_log < 256) begin
      lb[n_log] <= int'(iss_bank);
      lr[n_log] <= int'(iss_row);
      lc[n_log] <= int'(iss_col);
      lt[n_log] <= int'(iss_thr);
      lh[n_log] <= int'(iss_hit);
      lk[n_log] <= cyc;
      n_log <= n_log + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic enq(input int b, input int r, input int c, input int t, output bit acc);
    @(negedge clk);
    in_valid = 1'b1;
    in_bank  = BANK_W'(b);
    in_row   = ROW_W'(r);
    in_col   = COL_W'(c);
    in_thr   = THR_W'(t);
    in_write = c[0];
    acc      = in_ready;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic int tcount(input int t);
    return int'(thr_count[t*CNT_W +: CNT_W]);
  endfunction

  task automatic t_reset;
    @(negedge clk);
    check(iss_valid == 1'b0, "R9", "iss_valid after reset", int'(iss_valid), 0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);
    check(thr_count == '0, "R9", "counters after reset", int'(thr_count[31:0]), 0);
  endtask

  task automatic t_hit_first;
    int base;
    bit a;
    base = n_log;
    enq(0, 1, 0, 0, a);
    enq(0, 2, 1, 0, a);
    enq(0, 1, 2, 1, a);
    enq(0, 3, 3, 0, a);
    enq(0, 1, 4, 1, a);
    idle(14);
    check(n_log - base == 5, "R6", "issues in hit-first test", n_log - base, 5);
    check(lh[base] == 0, "R4", "cold bank access is conflict", lh[base], 0);
    check(lc[base+1] == 2, "R1", "first after busy is oldest hit", lc[base+1], 2);
    check(lc[base+2] == 4, "R1", "second hit before older conflict", lc[base+2], 4);
    check(lh[base+1] == 1 && lh[base+2] == 1, "R1", "hits flagged", lh[base+1] + lh[base+2], 2);
    check(lc[base+3] == 1, "R2", "oldest conflict next", lc[base+3], 1);
    check(lc[base+4] == 3, "R2", "younger conflict last", lc[base+4], 3);
    check(lk[base+1] - lk[base] == 4, "R3", "conflict busy span", lk[base+1] - lk[base], 4);
    check(lk[base+2] - lk[base+1] == 1, "R3", "hit busy span", lk[base+2] - lk[base+1], 1);
    check(lk[base+4] - lk[base+3] == 4, "R3", "second conflict busy span", lk[base+4] - lk[base+3], 4);
    base = n_log;
    enq(0, 1, 5, 0, a);
    idle(8);
    check(lh[base] == 0, "R4", "row 1 replaced by row 3", lh[base], 0);
    enq(0, 1, 6, 0, a);
    idle(3);
    check(lh[base+1] == 1, "R4", "row 1 reopened gives hit", lh[base+1], 1);
  endtask

  task automatic t_bank_parallel;
    int base;
    bit a;
    base = n_log;
    enq(1, 3, 10, 2, a);
    enq(1, 3, 11, 2, a);
    enq(3, 9, 12, 2, a);
    idle(10);
    check(n_log - base == 3, "R3", "issues in parallel test", n_log - base, 3);
    check(lb[base+1] == 3, "R3", "free bank overtakes busy bank", lb[base+1], 3);
    check(lk[base+1] - lk[base] == 2, "R6", "issue one cycle after acceptance", lk[base+1] - lk[base], 2);
    check(lc[base+2] == 11 && lh[base+2] == 1, "R3", "busy bank request after busy span", lc[base+2], 11);
    check(lk[base+2] - lk[base] == 4, "R3", "busy bank wait", lk[base+2] - lk[base], 4);
  endtask

  task automatic t_streak;
    int base, c0, c1;
    bit a;
    base = n_log;
    c0 = tcount(0);
    c1 = tcount(1);
    enq(2, 7, 0, 0, a);
    enq(2, 20, 0, 1, a);
    for (int i = 0; i < 20; i++) enq(2, 7, i + 1, 0, a);
    idle(30);
    check(n_log - base == 22, "R7", "issues in streak test", n_log - base, 22);
    check(lt[base+21] == 1, "R7", "older conflict starved to last", lt[base+21], 1);
    check(lk[base+21] - lk[base+20] == 1, "R7", "conflict right after stream ends", lk[base+21] - lk[base+20], 1);
    check(tcount(0) - c0 == 21, "R8", "thread 0 counter delta", tcount(0) - c0, 21);
    check(tcount(1) - c1 == 1, "R8", "thread 1 counter delta", tcount(1) - c1, 1);
  endtask

  task automatic t_fill;
    int base, acc_n, ok_order;
    bit a, saw_full;
    base = n_log;
    acc_n = 0;
    saw_full = 1'b0;
    for (int i = 0; i < 30; i++) begin
      enq(0, 64 + acc_n, acc_n, 3, a);
      if (a) acc_n++;
      else saw_full = 1'b1;
    end
    idle(100);
    check(saw_full, "R5", "in_ready low when pool full", int'(saw_full), 1);
    check(n_log - base == acc_n, "R5", "issued equals accepted", n_log - base, acc_n);
    ok_order = 1;
    for (int i = 0; i < acc_n; i++)
      if (lr[base+i] != 64 + i || lh[base+i] != 0) ok_order = 0;
    check(ok_order == 1, "R2", "conflicts issued in arrival order", ok_order, 1);
    check(in_ready == 1'b1 && iss_valid == 1'b0, "R5", "pool drained", int'(in_ready), 1);
  endtask

  task automatic t_counters;
    int exp[NTHR];
    for (int t = 0; t < NTHR; t++) exp[t] = 0;
    for (int i = 0; i < n_log; i++) exp[lt[i]]++;
    for (int t = 0; t < NTHR; t++)
      check(tcount(t) == exp[t], "R8", "thread counter total", tcount(t), exp[t]);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hit_first();
    t_bank_parallel();
    t_streak();
    t_fill();
    t_counters();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule